// File: doc/BRIEF.md
# Scatter-Gather Disk DMA Engine

This block is the bus-master half of a disk controller's DMA path. The device state machine first arms the engine when it enters its DMA data phase. The engine then accepts a start carrying a descriptor-table base address, the command's total byte count and a direction flag. It walks the descriptor table in memory, one 8-byte entry at a time. Each entry names a memory region. The engine moves each region in bursts that stay inside one memory page, and it reports whole disk sectors on a sector port as the bytes accumulate.

The memory side is a single request channel. The engine holds a request with address, length and write flag, and memory answers with either a busy or a grant. Busy always overrides grant. A busy answer makes the engine drop the request for a fixed number of cycles and then issue the identical request again. A grant on a descriptor fetch carries the 64-bit descriptor on the read-data bus.

A transfer ends in one of two ways. It ends in a one-cycle done pulse when the end-of-table region completes and the command's byte budget is used exactly. Otherwise it ends in a one-cycle error pulse: when a region oversteps the budget, when end-of-table arrives with bytes still owed, or on an abort.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset the engine is idle: no memory request, and done, error and sector strobe are all low.
- R2: A start is honoured only after an arm has moved the engine into its start-pending state; a start while idle is ignored. An honoured start samples table base, byte count and direction. The first descriptor request then appears on the second clock edge after the start edge, and there is no request in between.
- R3: Descriptor fetches are reads of length 8 at table base + 8*i for the i-th entry. The 64-bit descriptor holds the region base in bits 31:0, the region byte count in bits 47:32 (zero means 65536) and end-of-table in bit 63.
- R4: Each burst length is the smaller of the bytes left in the region and the bytes left before the next page boundary (default page 4096). A burst never crosses a page. Each burst starts at region base plus the bytes already moved in that region.
- R5: With direction 1 (disk to memory) every burst request has the write flag set; with direction 0 (memory to disk) every burst is a read.
- R6: A request answered with busy is withdrawn for exactly BACKOFF_CYC cycles (default 4) and then reissued with the same address and length; busy wins over a grant in the same cycle.
- R7: On the cycle after each granted burst, the sector strobe pulses with the count of whole 512-byte sectors completed if that count is non-zero. A partial sector is carried into later bursts, including bursts of the next region.
- R8: A descriptor whose byte count exceeds the command's remaining bytes ends the command with an error pulse and no burst for that region.
- R9: When the end-of-table region completes, the engine returns to idle and pulses done if the remaining byte count is zero, otherwise error; done and error never pulse together.
- R10: An abort while armed or transferring ends the command with an error pulse and no further requests. An abort while idle is ignored. An abort in the same cycle as a grant cancels that grant: no sector strobe and no done follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Device entered DMA data phase; idle to start-pending |
| start_i | input | 1 | Start pulse, honoured while start-pending |
| dir_to_mem_i | input | 1 | 1: disk to memory (memory writes); 0: memory to disk |
| table_base_i | input | 32 | Descriptor table base address |
| cmd_bytes_i | input | CMD_W | Total bytes of the command |
| abort_i | input | 1 | Abort the command |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory request address |
| mem_len_o | output | 17 | Memory request byte length |
| mem_busy_i | input | 1 | Memory busy; request must back off |
| mem_gnt_i | input | 1 | Memory grant; request completes this cycle |
| mem_rdata_i | input | 64 | Descriptor returned with a fetch grant |
| disk_stb_o | output | 1 | Whole sectors handed to the disk port |
| disk_nsect_o | output | NS_W | Number of whole sectors in this strobe |
| done_o | output | 1 | Command completed cleanly (pulse) |
| err_o | output | 1 | Command ended with an error (pulse) |

## Verification
The sharp overlap is an abort that lands in the same cycle as the grant of the last burst. Both want to end the command, and only the abort may win. The bench provokes it by raising abort on the exact cycle the final burst request is presented while the memory model grants it. It judges the outcome by an error pulse with no done and no sector strobe. A second overlap is busy raised together with grant, which must be read as busy. The bench judges that by the measured gap before the identical request returns and by burst and sector totals left unchanged.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
  localparam int DMA_AW     = 32;   // address width
  localparam int RGN_W      = 17;   // region byte count incl. the 64 KiB case
  localparam int DESC_BYTES = 8;    // one descriptor in memory
  localparam int DESC_W     = 64;

  typedef enum logic [2:0] {
    S_IDLE, S_PEND, S_LAUNCH, S_FETCH, S_BURST, S_BACKOFF
  } dma_state_t;

  typedef struct packed {
    logic        eot;
    logic [14:0] rsvd;
    logic [15:0] count;
    logic [31:0] base;
  } desc_t;

  // zero in the count field stands for the largest region
  function automatic logic [RGN_W-1:0] region_bytes(input logic [15:0] f);
    return (f == 16'd0) ? RGN_W'(65536) : RGN_W'(f);
  endfunction

  // bytes from address up to the next page boundary
  function automatic logic [RGN_W-1:0] page_room(input logic [DMA_AW-1:0] a,
                                                 input int unsigned page_bytes);
    logic [DMA_AW-1:0] pg, off;
    pg  = DMA_AW'(page_bytes);
    off = a & (pg - 1'b1);
    return RGN_W'(pg - off);
  endfunction

  function automatic logic [RGN_W-1:0] burst_len(input logic [DMA_AW-1:0] a,
                                                 input logic [RGN_W-1:0] left,
                                                 input int unsigned page_bytes);
    logic [RGN_W-1:0] room;
    room = page_room(a, page_bytes);
    return (left < room) ? left : room;
  endfunction
endpackage

// File: rtl/dma_burst_calc.sv
module dma_burst_calc
  import prd_dma_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic [DMA_AW-1:0] rgn_base,
  input  logic [RGN_W-1:0]  rgn_total,
  input  logic [RGN_W-1:0]  moved,
  output logic [DMA_AW-1:0] b_addr,
  output logic [RGN_W-1:0]  b_len,
  output logic              b_last
);
  logic [RGN_W-1:0] left;
  always_comb begin
    left   = rgn_total - moved;
    b_addr = rgn_base + DMA_AW'(moved);
    b_len  = burst_len(b_addr, left, PAGE_BYTES);
    b_last = (b_len == left);
  end
endmodule

// File: rtl/dma_backoff.sv
module dma_backoff #(
  parameter int BACKOFF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = (BACKOFF_CYC < 2) ? 1 : $clog2(BACKOFF_CYC);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(BACKOFF_CYC - 1);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign expired = (cnt == '0);
endmodule

// File: rtl/dma_sector_pack.sv
module dma_sector_pack #(
  parameter int SECTOR_BYTES = 512,
  parameter int LEN_W        = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic [LEN_W-1:0] len,
  output logic             stb,
  output logic [LEN_W-$clog2(SECTOR_BYTES):0] nsect
);
  localparam int SW = $clog2(SECTOR_BYTES);
  logic [SW-1:0]  acc;
  logic [LEN_W:0] sum;
  assign sum = (LEN_W+1)'(acc) + (LEN_W+1)'(len);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc   <= '0;
      stb   <= 1'b0;
      nsect <= '0;
    end else if (add) begin
      acc   <= sum[SW-1:0];
      stb   <= (sum[LEN_W:SW] != '0);
      nsect <= sum[LEN_W:SW];
    end else begin
      stb   <= 1'b0;
      nsect <= '0;
    end
  end
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
  import prd_dma_pkg::*;
#(
  parameter int unsigned PAGE_BYTES   = 4096,
  parameter int          SECTOR_BYTES = 512,
  parameter int          BACKOFF_CYC  = 4,
  parameter int          CMD_W        = 24,
  localparam int         NS_W         = RGN_W + 1 - $clog2(SECTOR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              start_i,
  input  logic              dir_to_mem_i,
  input  logic [DMA_AW-1:0] table_base_i,
  input  logic [CMD_W-1:0]  cmd_bytes_i,
  input  logic              abort_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DMA_AW-1:0] mem_addr_o,
  output logic [RGN_W-1:0]  mem_len_o,
  input  logic              mem_busy_i,
  input  logic              mem_gnt_i,
  input  logic [DESC_W-1:0] mem_rdata_i,
  output logic              disk_stb_o,
  output logic [NS_W-1:0]   disk_nsect_o,
  output logic              done_o,
  output logic              err_o
);
  dma_state_t        state;
  logic [DMA_AW-1:0] ptr, rgn_base;
  logic [RGN_W-1:0]  rgn_total, moved;
  logic [CMD_W-1:0]  remain;
  logic              eot, dir_q, ret_burst;

  // named internal events, used by the checker
  logic ev_active, ev_fetch_req, ev_burst_req, ev_backoff;
  logic ev_abort, ev_busy, ev_grant;
  assign ev_active    = (state != S_IDLE);
  assign ev_fetch_req = (state == S_FETCH);
  assign ev_burst_req = (state == S_BURST);
  assign ev_backoff   = (state == S_BACKOFF);
  assign ev_abort     = abort_i && ev_active;
  assign ev_busy      = mem_req_o && mem_busy_i && !ev_abort;
  assign ev_grant     = mem_req_o && mem_gnt_i && !mem_busy_i && !ev_abort;

  logic [DMA_AW-1:0] b_addr;
  logic [RGN_W-1:0]  b_len;
  logic              b_last, bo_expired;

  dma_burst_calc #(.PAGE_BYTES(PAGE_BYTES)) u_calc (
    .rgn_base(rgn_base), .rgn_total(rgn_total), .moved(moved),
    .b_addr(b_addr), .b_len(b_len), .b_last(b_last)
  );

  dma_backoff #(.BACKOFF_CYC(BACKOFF_CYC)) u_bo (
    .clk(clk), .rst_n(rst_n), .load(ev_busy), .expired(bo_expired)
  );

  dma_sector_pack #(.SECTOR_BYTES(SECTOR_BYTES), .LEN_W(RGN_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .clr(state == S_PEND && start_i && !ev_abort),
    .add(ev_burst_req && ev_grant), .len(b_len),
    .stb(disk_stb_o), .nsect(disk_nsect_o)
  );

  desc_t            desc;
  logic [RGN_W-1:0] d_bytes;
  logic             d_overrun;
  assign desc      = desc_t'(mem_rdata_i);
  assign d_bytes   = region_bytes(desc.count);
  assign d_overrun = CMD_W'(d_bytes) > remain;

  assign mem_req_o  = ev_fetch_req || ev_burst_req;
  assign mem_we_o   = ev_burst_req && dir_q;
  assign mem_addr_o = ev_fetch_req ? ptr : b_addr;
  assign mem_len_o  = ev_fetch_req ? RGN_W'(DESC_BYTES) : b_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;   ptr <= '0;     rgn_base <= '0;
      rgn_total <= '0;   moved <= '0;   remain <= '0;
      eot <= 1'b0;       dir_q <= 1'b0; ret_burst <= 1'b0;
      done_o <= 1'b0;    err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (ev_abort) begin
        state <= S_IDLE;
        err_o <= 1'b1;
      end else begin
        unique case (state)
          S_IDLE:   if (arm_i) state <= S_PEND;
          S_PEND:   if (start_i) begin
                      state  <= S_LAUNCH;
                      ptr    <= table_base_i;
                      remain <= cmd_bytes_i;
                      dir_q  <= dir_to_mem_i;
                    end
          S_LAUNCH: state <= S_FETCH;
          S_FETCH:  if (ev_busy) begin
                      state <= S_BACKOFF; ret_burst <= 1'b0;
                    end else if (ev_grant) begin
                      ptr       <= ptr + DMA_AW'(DESC_BYTES);
                      rgn_base  <= desc.base;
                      rgn_total <= d_bytes;
                      moved     <= '0;
                      eot       <= desc.eot;
                      if (d_overrun) begin
                        state <= S_IDLE; err_o <= 1'b1;
                      end else begin
                        remain <= remain - CMD_W'(d_bytes);
                        state  <= S_BURST;
                      end
                    end
          S_BURST:  if (ev_busy) begin
                      state <= S_BACKOFF; ret_burst <= 1'b1;
                    end else if (ev_grant) begin
                      moved <= moved + b_len;
                      if (b_last) begin
                        if (!eot) state <= S_FETCH;
                        else begin
                          state <= S_IDLE;
                          if (remain == '0) done_o <= 1'b1;
                          else              err_o  <= 1'b1;
                        end
                      end
                    end
          S_BACKOFF: if (bo_expired) state <= ret_burst ? S_BURST : S_FETCH;
          default:   state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/prd_dma_chk.sv
module prd_dma_chk
  import prd_dma_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = 4096,
  parameter int          BACKOFF_CYC = 4,
  parameter int          NS_W        = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic              mem_busy_i,
  input logic [DMA_AW-1:0] mem_addr_o,
  input logic [RGN_W-1:0]  mem_len_o,
  input logic              abort_i,
  input logic              done_o,
  input logic              err_o,
  input logic              disk_stb_o,
  input logic [NS_W-1:0]   disk_nsect_o,
  input logic              ev_active,
  input logic              ev_burst_req,
  input logic              ev_backoff
);
  logic [DMA_AW:0] span;
  assign span = {1'b0, mem_addr_o & DMA_AW'(PAGE_BYTES - 1)} + (DMA_AW+1)'(mem_len_o);

  logic [15:0] bo_run;
  always_ff @(posedge clk) begin
    if (!rst_n)          bo_run <= '0;
    else if (ev_backoff) bo_run <= bo_run + 1'b1;
    else                 bo_run <= '0;
  end

  // R4
  page_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_burst_req |-> (span <= (DMA_AW+1)'(PAGE_BYTES)) && (mem_len_o != '0));
  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_busy_i && !abort_i) |=> (ev_backoff && !mem_req_o));
  // R6
  backoff_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bo_run <= 16'(BACKOFF_CYC));
  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
  // R9
  done_after_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(ev_burst_req));
  // R10
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_i && ev_active) |=> (err_o && !done_o && !mem_req_o));
  // R7
  stb_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disk_stb_o |-> (disk_nsect_o != '0));
endmodule

bind prd_dma_engine prd_dma_chk #(
  .PAGE_BYTES(PAGE_BYTES), .BACKOFF_CYC(BACKOFF_CYC), .NS_W(NS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_busy_i(mem_busy_i),
  .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o), .abort_i(abort_i),
  .done_o(done_o), .err_o(err_o), .disk_stb_o(disk_stb_o),
  .disk_nsect_o(disk_nsect_o), .ev_active(ev_active),
  .ev_burst_req(ev_burst_req), .ev_backoff(ev_backoff)
);

// File: tb/sim_prd_dma_engine.sv
module sim_prd_dma_engine;
  localparam int CLK_PERIOD = 10;
  localparam int BO_CYC     = 4;
  localparam int PG         = 4096;
  localparam logic [31:0] TBASE = 32'h0000_1000;

  typedef struct packed {
    logic        dir;
    logic [1:0]  nreg;
    logic [31:0] b0;
    logic [15:0] c0;
    logic [31:0] b1;
    logic [15:0] c1;
    logic [23:0] cmd;
    logic [7:0]  nb;
    logic [15:0] ns;
    logic        ok;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b1, 2'd1, 32'h0,     16'h0200, 32'h0,    16'h0,   24'h000200, 8'd1,  16'd1,   1'b1},
    '{1'b0, 2'd1, 32'h0F00,  16'h0400, 32'h0,    16'h0,   24'h000400, 8'd2,  16'd2,   1'b1},
    '{1'b1, 2'd2, 32'h2000,  16'h0100, 32'h5000, 16'h100, 24'h000200, 8'd2,  16'd1,   1'b1},
    '{1'b0, 2'd1, 32'h0,     16'h3000, 32'h0,    16'h0,   24'h003000, 8'd3,  16'd24,  1'b1},
    '{1'b1, 2'd1, 32'h10000, 16'h0000, 32'h0,    16'h0,   24'h010000, 8'd16, 16'd128, 1'b1},
    '{1'b0, 2'd1, 32'h0,     16'h0400, 32'h0,    16'h0,   24'h000200, 8'd0,  16'd0,   1'b0},
    '{1'b1, 2'd1, 32'h0,     16'h0200, 32'h0,    16'h0,   24'h000400, 8'd1,  16'd1,   1'b0},
    '{1'b0, 2'd1, 32'h07FE,  16'h1000, 32'h0,    16'h0,   24'h001000, 8'd2,  16'd8,   1'b1},
    '{1'b1, 2'd2, 32'h0,     16'h0200, 32'h3000, 16'h400, 24'h000400, 8'd1,  16'd1,   1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        arm_i = 0, start_i = 0, dir_to_mem_i = 0, abort_i = 0;
  logic [31:0] table_base_i = '0;
  logic [23:0] cmd_bytes_i = '0;
  logic        mem_req_o, mem_we_o, mem_busy_i = 0, mem_gnt_i = 0;
  logic [31:0] mem_addr_o;
  logic [16:0] mem_len_o;
  logic [63:0] mem_rdata_i = '0;
  logic        disk_stb_o, done_o, err_o;
  logic [8:0]  disk_nsect_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  prd_dma_engine #(.PAGE_BYTES(PG), .SECTOR_BYTES(512), .BACKOFF_CYC(BO_CYC), .CMD_W(24)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .start_i(start_i),
    .dir_to_mem_i(dir_to_mem_i), .table_base_i(table_base_i),
    .cmd_bytes_i(cmd_bytes_i), .abort_i(abort_i), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_len_o(mem_len_o),
    .mem_busy_i(mem_busy_i), .mem_gnt_i(mem_gnt_i), .mem_rdata_i(mem_rdata_i),
    .disk_stb_o(disk_stb_o), .disk_nsect_o(disk_nsect_o),
    .done_o(done_o), .err_o(err_o)
  );

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and observers (written only here)
  int cur = 0, run_id = 0, busy_req = 0;
  bit busy_on_fetch = 0;
  int n_done = 0, n_errc = 0, n_sect = 0, n_burst = 0, bad_fetch = 0, bad_burst = 0;
  int bad_dir = 0, n_cross = 0, busy_used = 0, bo_seen = 0, bo_bad = 0;
  int last_run = -1, f_idx = 0, bo_gap = 0;
  bit bo_wait = 0;
  logic [31:0] bo_addr, exp_addr;
  logic [16:0] bo_len;
  longint exp_left;

  always @(negedge clk) begin
    longint room, elen;
    logic [15:0] c;
    if (last_run != run_id) begin last_run = run_id; f_idx = 0; end
    if (done_o) n_done++;
    if (err_o) n_errc++;
    if (disk_stb_o) n_sect += int'(disk_nsect_o);
    if (bo_wait) begin
      if (!mem_req_o) bo_gap++;
      else begin
        bo_seen++;
        if (bo_gap != BO_CYC || mem_addr_o != bo_addr || mem_len_o != bo_len) bo_bad++;
        bo_wait = 0;
      end
    end
    mem_busy_i = 0; mem_gnt_i = 0;
    if (mem_req_o) begin
      mem_gnt_i = 1;
      if (busy_used < busy_req && ((mem_len_o == 17'd8) == busy_on_fetch)) begin
        busy_used++; mem_busy_i = 1;   // busy together with grant: busy must win
        bo_wait = 1; bo_gap = 0; bo_addr = mem_addr_o; bo_len = mem_len_o;
      end else if (mem_len_o == 17'd8) begin
        if (mem_addr_o != TBASE + 32'(8*f_idx) || mem_we_o) bad_fetch++;
        if (f_idx == 0) begin
          mem_rdata_i = {VEC[cur].nreg == 2'd1, 15'd0, VEC[cur].c0, VEC[cur].b0};
          exp_addr = VEC[cur].b0; c = VEC[cur].c0;
        end else begin
          mem_rdata_i = {1'b1, 15'd0, VEC[cur].c1, VEC[cur].b1};
          exp_addr = VEC[cur].b1; c = VEC[cur].c1;
        end
        exp_left = (c == 16'd0) ? 65536 : longint'(c);
        f_idx++;
      end else begin
        n_burst++;
        room = PG - longint'(exp_addr % PG);
        elen = (exp_left < room) ? exp_left : room;
        if (mem_addr_o != exp_addr || longint'(mem_len_o) != elen) bad_burst++;
        if (mem_we_o != VEC[cur].dir) bad_dir++;
        if (longint'(mem_addr_o % PG) + longint'(mem_len_o) > PG) n_cross++;
        exp_addr = exp_addr + 32'(mem_len_o);
        exp_left = exp_left - longint'(mem_len_o);
      end
    end
  end

  task automatic launch(input int k);
    cur = k; run_id++;
    @(negedge clk) arm_i = 1;
    @(negedge clk) arm_i = 0; start_i = 1; dir_to_mem_i = VEC[k].dir;
                   table_base_i = TBASE; cmd_bytes_i = VEC[k].cmd;
    @(negedge clk) start_i = 0;
  endtask

  task automatic run_vec(input int k, input bit bfetch, input int nbusy);
    int d0, e0, s0, b0, f0, x0, w0, c0, bs0, bb0;
    busy_on_fetch = bfetch; busy_req += nbusy;
    d0 = n_done; e0 = n_errc; s0 = n_sect; b0 = n_burst; f0 = bad_fetch;
    x0 = bad_burst; w0 = bad_dir; c0 = n_cross; bs0 = bo_seen; bb0 = bo_bad;
    launch(k);
    for (int t = 0; t < 30000 && n_done == d0 && n_errc == e0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk((n_done - d0) == int'(VEC[k].ok), $sformatf("R9 done count v%0d", k), n_done - d0, VEC[k].ok);
    chk((n_errc - e0) == int'(!VEC[k].ok), $sformatf("R8 R9 error count v%0d", k), n_errc - e0, !VEC[k].ok);
    chk((n_burst - b0) == int'(VEC[k].nb), $sformatf("R4 burst count v%0d", k), n_burst - b0, VEC[k].nb);
    chk((bad_burst - x0) == 0 && (n_cross - c0) == 0, $sformatf("R4 burst shape v%0d", k), bad_burst - x0, 0);
    chk((bad_fetch - f0) == 0, $sformatf("R3 fetch address v%0d", k), bad_fetch - f0, 0);
    chk((bad_dir - w0) == 0, $sformatf("R5 write flag v%0d", k), bad_dir - w0, 0);
    chk((n_sect - s0) == int'(VEC[k].ns), $sformatf("R7 sectors v%0d", k), n_sect - s0, VEC[k].ns);
    if (nbusy != 0)
      chk((bo_seen - bs0) == nbusy && (bo_bad - bb0) == 0, $sformatf("R6 backoff retry v%0d", k),
          bo_bad - bb0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit seen;
    int s0, d0, e0;
    repeat (4) @(negedge clk);
    chk(!mem_req_o && !done_o && !err_o && !disk_stb_o, "R1 reset outputs",
        {mem_req_o, done_o, err_o, disk_stb_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_req_o, "R1 idle after reset", mem_req_o, 0);

    // R2 / R10: start and abort while idle are ignored
    start_i = 1; abort_i = 1;
    @(negedge clk) start_i = 0; abort_i = 0;
    seen = 0;
    repeat (6) begin @(negedge clk); if (mem_req_o || err_o) seen = 1; end
    chk(!seen, "R2 R10 idle ignores start and abort", seen, 0);

    // R2: launch timing
    cur = 0; run_id++;
    @(negedge clk) arm_i = 1;
    @(negedge clk) arm_i = 0; start_i = 1; dir_to_mem_i = 1; table_base_i = TBASE;
                   cmd_bytes_i = 24'h200;
    @(negedge clk) start_i = 0;
    chk(!mem_req_o, "R2 no request one edge after start", mem_req_o, 0);
    @(negedge clk);
    chk(mem_req_o && mem_addr_o == TBASE && mem_len_o == 17'd8 && !mem_we_o,
        "R2 R3 first fetch", mem_addr_o, TBASE);
    repeat (10) @(negedge clk);

    for (int k = 0; k < 9; k++) run_vec(k, 1'b0, 0);
    run_vec(3, 1'b1, 1);   // R6 busy on a descriptor fetch
    run_vec(1, 1'b0, 1);   // R6 busy on a burst

    // R10: abort while start-pending
    @(negedge clk) arm_i = 1;
    @(negedge clk) arm_i = 0; abort_i = 1;
    @(negedge clk) abort_i = 0;
    chk(err_o && !mem_req_o, "R10 abort while pending", err_o, 1);
    @(negedge clk) start_i = 1;
    @(negedge clk) start_i = 0;
    seen = 0;
    repeat (4) begin @(negedge clk); if (mem_req_o) seen = 1; end
    chk(!seen, "R2 start after abort ignored", seen, 0);

    // R10: abort in the middle of a long transfer
    d0 = n_done;
    launch(4);
    do @(negedge clk); while (!(mem_req_o && mem_len_o != 17'd8));
    repeat (3) @(negedge clk);
    abort_i = 1;
    @(negedge clk) abort_i = 0;
    chk(err_o && !mem_req_o, "R10 abort mid transfer", err_o, 1);
    repeat (10) @(negedge clk);
    chk(n_done == d0 && !mem_req_o, "R10 no done after abort", n_done - d0, 0);

    // R10: abort together with the grant of the final burst
    launch(0);
    do @(negedge clk); while (!(mem_req_o && mem_len_o != 17'd8));
    s0 = n_sect; d0 = n_done; e0 = n_errc;
    abort_i = 1;
    @(negedge clk) abort_i = 0;
    chk(err_o && !done_o, "R10 abort beats final grant", {err_o, done_o}, 2'b10);
    repeat (5) @(negedge clk);
    chk(n_sect == s0 && n_done == d0, "R10 R7 cancelled grant gives no sector", n_sect - s0, 0);
    chk(n_errc - e0 == 1, "R10 single error pulse", n_errc - e0, 1);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule